// File: doc/BRIEF.md
# Serial ASCII integer radix parser

This block sits behind a UART receiver and turns a stream of ASCII bytes into a signed integer for a four-digit seven-segment display. Each byte arrives with a one-cycle valid strobe. The first byte of a number may pick the radix: hexadecimal, binary, octal or decimal. Any number of minus signs may follow, and then the digits. The number is accumulated in a 16-bit register as it arrives. It is committed to the output only when a carriage return or line feed arrives.

The committed value is a signed 16-bit register. From it, combinational logic derives a sign flag, a flag that marks a magnitude too large for three decimal digits, and four display digit codes. A digit multiplexer that drives the segments consumes these codes. The UART receiver and the digit multiplexing are outside this block.

Support for negative numbers is a build-time parameter. The reset input is asynchronous and active low. Inside the block it is released synchronously, two clock edges after the pin rises.

Top module: `ascii_num_parser`

## Requirements
- R1: After reset, value_o is 0, too_large_o and neg_o are 0, and digits_o is 16'hFFF0 (three blanks, then a zero in the ones place).
- R2: Parsing is decimal when the first character of a number is a digit, or when the first character is d or D.
- R3: A first character of x, X, h or H selects hexadecimal. The hex digit characters are 0-9, a-f and A-F.
- R4: A first character of b or B selects binary, and a first character of o or O selects octal.
- R5: value_o, neg_o, too_large_o and digits_o change only in the cycle after a carriage return (0x0D) or line feed (0x0A) is accepted. At all other times they hold.
- R6: With NEG_EN=1, each minus sign (0x2D) that arrives before the first digit inverts the sign, whether or not a prefix came first. An even count of minus signs therefore gives a positive value.
- R7: With NEG_EN=0, a minus sign has no effect.
- R8: Any character that is not acted on is ignored. This covers a digit that is too large for the current radix, a non-digit, a prefix letter that is not the first character, and a minus sign after the first digit.
- R9: Each accepted digit sets acc = (acc*radix + digit) mod 2^16. The committed value is acc, or -acc mod 2^16 when the sign is set. neg_o is bit 15 of that value.
- R10: digits_o[15:12] is the leftmost digit and digits_o[3:0] the rightmost. Code 0-9 is a decimal digit, 0xA is a dash and 0xF is blank. The leftmost digit is a dash for a negative value and blank otherwise. The other three digits show the magnitude, with leading zeros blanked and the ones digit always shown.
- R11: When the magnitude exceeds 999, too_large_o is 1 and all four digits are dashes (16'hAAAA).
- R12: After a terminator, the next number starts fresh: accumulator 0, sign positive, decimal radix, and a prefix is accepted again. A terminator with no digits commits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Strobe: rx_byte holds a received character |
| rx_byte | input | 8 | Received ASCII character |
| value_o | output | 16 | Last committed signed value |
| too_large_o | output | 1 | Magnitude exceeds 999 |
| neg_o | output | 1 | Committed value is negative |
| digits_o | output | 16 | Four display digit codes, leftmost in the top nibble |

## Verification
The parser's internal state is invisible at the ports until the number ends. Its phase, radix, sign and accumulator show up only in the cycle after a terminator. A wrong radix, a lost sign toggle or a stray accepted character is therefore caught exactly one cycle after the next carriage return or line feed. For that reason every test string ends in a terminator, and the outputs are compared every cycle, so a value that changes at the wrong time is also caught. A second instance built without negative support receives the same bytes, so its handling of minus signs is checked on every cycle as well.

// File: rtl/numparse_pkg.sv
package numparse_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,   // expecting prefix, minus or digit
    PH_LEAD = 2'd1,   // after prefix or minus, before any digit
    PH_DIG  = 2'd2    // at least one digit accepted
  } phase_e;

  typedef enum logic [1:0] {
    RX_DEC = 2'd0,
    RX_HEX = 2'd1,
    RX_BIN = 2'd2,
    RX_OCT = 2'd3
  } radix_e;

  localparam logic [3:0] CODE_DASH  = 4'hA;
  localparam logic [3:0] CODE_BLANK = 4'hF;

  typedef struct packed {
    logic       is_term;
    logic       is_minus;
    logic       pfx_hit;
    radix_e     pfx_radix;
    logic       is_hexdig;
    logic [3:0] dig;
  } chr_s;

endpackage

// File: rtl/rst_sync.sv
module rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic s0_q, s1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_q <= 1'b0;
      s1_q <= 1'b0;
    end else begin
      s0_q <= 1'b1;
      s1_q <= s0_q;
    end
  end

  assign rst_sync_n = s1_q;
endmodule

// File: rtl/char_classify.sv
module char_classify
  import numparse_pkg::*;
(
  input  logic [7:0] ch,
  output chr_s       cls
);
  always_comb begin
    cls           = '0;
    cls.pfx_radix = RX_DEC;
    cls.is_term   = (ch == 8'h0D) || (ch == 8'h0A);
    cls.is_minus  = (ch == 8'h2D);
    unique case (ch)
      8'h78, 8'h58, 8'h68, 8'h48: begin cls.pfx_hit = 1'b1; cls.pfx_radix = RX_HEX; end
      8'h62, 8'h42:               begin cls.pfx_hit = 1'b1; cls.pfx_radix = RX_BIN; end
      8'h6F, 8'h4F:               begin cls.pfx_hit = 1'b1; cls.pfx_radix = RX_OCT; end
      8'h64, 8'h44:               begin cls.pfx_hit = 1'b1; cls.pfx_radix = RX_DEC; end
      default: ;
    endcase
    if (ch >= 8'h30 && ch <= 8'h39) begin
      cls.is_hexdig = 1'b1;
      cls.dig       = 4'(ch - 8'h30);
    end else if (ch >= 8'h61 && ch <= 8'h66) begin
      cls.is_hexdig = 1'b1;
      cls.dig       = 4'(ch - 8'h57);
    end else if (ch >= 8'h41 && ch <= 8'h46) begin
      cls.is_hexdig = 1'b1;
      cls.dig       = 4'(ch - 8'h37);
    end
  end
endmodule

// File: rtl/num_accum.sv
module num_accum
  import numparse_pkg::*;
#(
  parameter int ACC_W  = 16,
  parameter bit NEG_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  chr_s             cls,
  output logic [ACC_W-1:0] value_q
);
  localparam int PAD_W = ACC_W - 4;

  phase_e           phase_q, phase_n;
  radix_e           radix_q, radix_n;
  logic             sign_q, sign_n;
  logic [ACC_W-1:0] acc_q, acc_n, scaled, value_n;
  logic [3:0]       dmax;
  logic             dig_ok, minus_ok, pfx_ok, term_ok, upd_en;

  always_comb begin
    unique case (radix_q)
      RX_BIN:  dmax = 4'd1;
      RX_OCT:  dmax = 4'd7;
      RX_HEX:  dmax = 4'd15;
      default: dmax = 4'd9;
    endcase
    unique case (radix_q)
      RX_BIN:  scaled = acc_q << 1;
      RX_OCT:  scaled = acc_q << 3;
      RX_HEX:  scaled = acc_q << 4;
      default: scaled = (acc_q << 3) + (acc_q << 1);
    endcase
  end

  assign term_ok  = cls.is_term;
  assign pfx_ok   = !term_ok && cls.pfx_hit && (phase_q == PH_IDLE);
  assign minus_ok = NEG_EN && !term_ok && cls.is_minus && (phase_q != PH_DIG);
  assign dig_ok   = !term_ok && !pfx_ok && cls.is_hexdig && (cls.dig <= dmax);
  assign upd_en   = valid;

  // next-state
  always_comb begin
    phase_n = phase_q;
    radix_n = radix_q;
    sign_n  = sign_q;
    acc_n   = acc_q;
    value_n = sign_q ? -acc_q : acc_q;
    if (term_ok) begin
      phase_n = PH_IDLE;
      radix_n = RX_DEC;
      sign_n  = 1'b0;
      acc_n   = '0;
    end else if (pfx_ok) begin
      phase_n = PH_LEAD;
      radix_n = cls.pfx_radix;
    end else if (minus_ok) begin
      phase_n = PH_LEAD;
      sign_n  = !sign_q;
    end else if (dig_ok) begin
      phase_n = PH_DIG;
      acc_n   = scaled + {{PAD_W{1'b0}}, cls.dig};
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      radix_q <= RX_DEC;
      sign_q  <= 1'b0;
      acc_q   <= '0;
    end else if (upd_en) begin
      phase_q <= phase_n;
      radix_q <= radix_n;
      sign_q  <= sign_n;
      acc_q   <= acc_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 value_q <= '0;
    else if (valid && term_ok)  value_q <= value_n;
  end

  a_r5_value_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid && cls.is_term) |=> $stable(value_q));

  a_r12_fresh_after_term: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && cls.is_term) |=> (acc_q == '0) && !sign_q &&
                               (phase_q == PH_IDLE) && (radix_q == RX_DEC));

  a_r8_ignored_char: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !cls.is_term && !pfx_ok && !minus_ok && !dig_ok)
      |=> $stable(acc_q) && $stable(sign_q) && $stable(phase_q) && $stable(radix_q));

  a_r6_r7_minus_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && cls.is_minus && (phase_q != PH_DIG))
      |=> (sign_q == (NEG_EN ? !$past(sign_q) : $past(sign_q))));

endmodule

// File: rtl/disp_format.sv
module disp_format
  import numparse_pkg::*;
#(
  parameter int VAL_W = 16
) (
  input  logic [VAL_W-1:0] value,
  output logic [15:0]      digits,
  output logic             too_large,
  output logic             neg
);
  logic [VAL_W:0] vext, mag;
  logic [9:0]     m10;
  logic [3:0]     hund, tens, ones;

  always_comb begin
    neg       = value[VAL_W-1];
    vext      = {value[VAL_W-1], value};
    mag       = neg ? -vext : vext;
    too_large = mag > (VAL_W+1)'(999);
    m10       = 10'(mag);
    hund      = 4'(m10 / 10'd100);
    tens      = 4'((m10 / 10'd10) % 10'd10);
    ones      = 4'(m10 % 10'd10);
    if (too_large) begin
      digits = {4{CODE_DASH}};
    end else begin
      digits[15:12] = neg ? CODE_DASH : CODE_BLANK;
      digits[11:8]  = (hund == 4'd0) ? CODE_BLANK : hund;
      digits[7:4]   = (hund == 4'd0 && tens == 4'd0) ? CODE_BLANK : tens;
      digits[3:0]   = ones;
    end
  end
endmodule

// File: rtl/ascii_num_parser.sv
module ascii_num_parser
  import numparse_pkg::*;
#(
  parameter int ACC_W  = 16,
  parameter bit NEG_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic [7:0]       rx_byte,
  output logic [ACC_W-1:0] value_o,
  output logic             too_large_o,
  output logic             neg_o,
  output logic [15:0]      digits_o
);
  logic rst_int_n;
  chr_s cls;

  rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  char_classify u_cls (
    .ch  (rx_byte),
    .cls (cls)
  );

  num_accum #(.ACC_W(ACC_W), .NEG_EN(NEG_EN)) u_acc (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .valid   (rx_valid),
    .cls     (cls),
    .value_q (value_o)
  );

  disp_format #(.VAL_W(ACC_W)) u_disp (
    .value     (value_o),
    .digits    (digits_o),
    .too_large (too_large_o),
    .neg       (neg_o)
  );

  a_r11_all_dashes: assert property (@(posedge clk) disable iff (!rst_int_n)
    too_large_o |-> (digits_o == {4{CODE_DASH}}));

  a_r10_sign_digit: assert property (@(posedge clk) disable iff (!rst_int_n)
    !too_large_o |-> (digits_o[15:12] == (neg_o ? CODE_DASH : CODE_BLANK)));

  a_r10_ones_shown: assert property (@(posedge clk) disable iff (!rst_int_n)
    !too_large_o |-> (digits_o[3:0] <= 4'd9));

endmodule

// File: tb/tb_ascii_num_parser.sv
module tb_ascii_num_parser;
  localparam int CLK_P = 10;

  logic       clk, rst_n, rx_valid;
  logic [7:0] rx_byte;
  logic [15:0] val_w [2];
  logic [15:0] dig_w [2];
  logic        big_w [2];
  logic        neg_w [2];

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  string cur_req = "R1";

  // behavioural reference, one per instance (0: negatives on, 1: off)
  int        m_ph [2];
  int        m_rdx[2];
  int        m_acc[2];
  int        m_sgn[2];
  logic [15:0] m_val[2];

  ascii_num_parser dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .value_o(val_w[0]), .too_large_o(big_w[0]), .neg_o(neg_w[0]), .digits_o(dig_w[0]));

  ascii_num_parser #(.NEG_EN(1'b0)) dut_pos (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .value_o(val_w[1]), .too_large_o(big_w[1]), .neg_o(neg_w[1]), .digits_o(dig_w[1]));

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic model_reset();
    for (int i = 0; i < 2; i++) begin
      m_ph[i] = 0; m_rdx[i] = 10; m_acc[i] = 0; m_sgn[i] = 0; m_val[i] = 16'd0;
    end
  endtask

  task automatic model_byte(input logic [7:0] b);
    int d, pr;
    d = -1; pr = 0;
    if (b >= "0" && b <= "9") d = b - "0";
    else if (b >= "a" && b <= "f") d = b - "a" + 10;
    else if (b >= "A" && b <= "F") d = b - "A" + 10;
    if (b == "x" || b == "X" || b == "h" || b == "H") pr = 16;
    if (b == "b" || b == "B") pr = 2;
    if (b == "o" || b == "O") pr = 8;
    if (b == "d" || b == "D") pr = 10;
    for (int i = 0; i < 2; i++) begin
      if (b == 8'h0D || b == 8'h0A) begin
        m_val[i] = (m_sgn[i] != 0) ? 16'(65536 - m_acc[i]) : 16'(m_acc[i]);
        m_acc[i] = 0; m_sgn[i] = 0; m_rdx[i] = 10; m_ph[i] = 0;
      end else if (m_ph[i] == 0 && pr != 0) begin
        m_rdx[i] = pr; m_ph[i] = 1;
      end else if (b == "-" && i == 0 && m_ph[i] != 2) begin
        m_sgn[i] = 1 - m_sgn[i]; m_ph[i] = 1;
      end else if (d >= 0 && d < m_rdx[i]) begin
        m_acc[i] = (m_acc[i] * m_rdx[i] + d) % 65536; m_ph[i] = 2;
      end
    end
  endtask

  function automatic logic [15:0] exp_digits(input logic [15:0] v);
    int sv, mag, h, t, o;
    logic [15:0] r;
    sv  = (v >= 16'h8000) ? int'(v) - 65536 : int'(v);
    mag = (sv < 0) ? -sv : sv;
    if (mag > 999) return 16'hAAAA;
    h = mag / 100; t = (mag / 10) % 10; o = mag % 10;
    r[15:12] = (sv < 0) ? 4'hA : 4'hF;
    r[11:8]  = (h == 0) ? 4'hF : 4'(h);
    r[7:4]   = (h == 0 && t == 0) ? 4'hF : 4'(t);
    r[3:0]   = 4'(o);
    return r;
  endfunction

  task automatic compare();
    for (int i = 0; i < 2; i++) begin
      logic [15:0] ed;
      int sv;
      logic eb;
      ed = exp_digits(m_val[i]);
      sv = (m_val[i] >= 16'h8000) ? int'(m_val[i]) - 65536 : int'(m_val[i]);
      eb = (sv > 999) || (sv < -999);
      checks++;
      if (val_w[i] !== m_val[i] || dig_w[i] !== ed || big_w[i] !== eb ||
          neg_w[i] !== m_val[i][15]) begin
        errors++;
        $display("FAIL %s%s inst%0d: value=%h digits=%h big=%b neg=%b expected value=%h digits=%h big=%b neg=%b",
                 cur_req, (i == 1) ? "/R7" : "", i, val_w[i], dig_w[i], big_w[i], neg_w[i],
                 m_val[i], ed, eb, m_val[i][15]);
      end
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      compare();
    end
  endtask

  task automatic send(input logic [7:0] b);
    rx_valid = 1'b1; rx_byte = b;
    @(posedge clk); #1;
    model_byte(b);
    rx_valid = 1'b0; rx_byte = 8'h00;
    compare();
  endtask

  task automatic send_str(input string s, input int gap);
    for (int k = 0; k < s.len(); k++) begin
      send(s[k]);
      if (gap > 0) idle(gap);
    end
    idle(1);
  endtask

  initial begin
    rst_n = 1'b0; rx_valid = 1'b0; rx_byte = 8'h00;
    model_reset();
    cur_req = "R1";
    idle(3);
    rst_n = 1'b1;
    idle(4);
    cur_req = "R2";
    send_str("123\r", 0); send_str("d45\n", 0); send_str("D7\n", 0);
    cur_req = "R3";
    send_str("x1F\r", 0); send_str("hff\n", 0); send_str("HAbC\r", 0); send_str("X3e8\n", 0);
    cur_req = "R4";
    send_str("b101\n", 0); send_str("B11111\r", 0); send_str("o17\n", 0); send_str("O777\n", 0);
    cur_req = "R5";
    send_str("86\n", 2); send_str("x-c\r", 3);
    cur_req = "R6";
    send_str("-42\n", 0); send_str("--42\n", 0); send_str("---7\n", 0); send_str("x-A\n", 0);
    send_str("b--11\n", 0);
    cur_req = "R8";
    send_str("o19\n", 0); send_str("1z2\n", 0); send_str("1-2\n", 0); send_str("5x\n", 0);
    send_str("-xd\n", 0); send_str("b1021\n", 0);
    cur_req = "R9";
    send_str("x12345\n", 0); send_str("70000\n", 0); send_str("-x8000\n", 0); send_str("-1\n", 0);
    cur_req = "R10";
    send_str("0\n", 0); send_str("7\n", 0); send_str("40\n", 0); send_str("305\n", 0);
    send_str("-5\n", 0); send_str("-60\n", 0);
    cur_req = "R11";
    send_str("999\n", 0); send_str("1000\n", 0); send_str("-999\n", 0); send_str("-1000\n", 0);
    cur_req = "R12";
    send_str("-9\n", 0); send_str("\n", 0); send_str("x7\r", 0); send_str("b1\n", 0);
    send_str("\r\n", 0);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule